// File: doc/BRIEF.md
# NAND Flash Command and Address Decoder

This block is the control front end of an 8-bit multiplexed flash device. A single byte bus carries commands, addresses and write data. The two latch-select inputs decide how each byte is used, and a byte is taken on the rising edge of the write strobe while the chip select is low. The block decodes the two-byte operation sequences and models a page register of `PAGE_BYTES` bytes. It runs a busy timer whose length is set per operation by a parameter. On each falling edge of the read strobe it returns a status byte, an identification byte or a page-register byte.

The device pins are sampled by a system clock `clk_i`. Both strobes are edge-detected in that clock domain. The read output is registered and updates once per read-strobe falling edge. The latched page address is driven to the array side on `page_o`. The cell array itself is not part of this block.

Top module: `nand_cmd_decoder`

## Requirements
- R1: With `ce_ni` low, a rising `we_ni` edge takes `io_i` as follows: a command when `cle_i`=1 and `ale_i`=0, an address byte when `ale_i`=1 and `cle_i`=0, and data when both are 0. With `ce_ni` high, strobe edges have no effect.
- R2: An address has four bytes. Byte 1 sets column[7:0]. Byte 2 sets column[11:8] from `io_i[3:0]`. Byte 3 sets page[7:0] and byte 4 sets page[15:8]. Any further address byte is ignored. `page_o` shows the latched page.
- R3: The sequence 00h, address, 30h holds `rdy_o` low for `READ_BUSY` cycles. After that, each read-strobe fall returns the page-register byte at the current column and then advances the column by one.
- R4: The sequence 05h, two column bytes, E0h moves the read column without a busy period.
- R5: The sequence 80h, address, data bytes, 10h stores each data byte at the current column and advances the column. The 10h starts a busy period of `PROG_BUSY` cycles. When it completes with `wp_ni` high, status bit 0 reads 0.
- R6: The sequence 60h, two page bytes, D0h starts a busy period of `ERASE_BUSY` cycles. The block address is taken from page[15:6].
- R7: After 70h, every read-strobe fall returns a status byte. Bit 0 is fail (1), bit 5 is ready (1), bit 7 is write-enabled (1, copy of `wp_ni`), and all other bits are 0.
- R8: After 90h and an address byte 00h, successive reads return 98h, F1h, 00h, 15h, 40h. Reads beyond the last byte repeat 40h.
- R9: While busy, only 70h and FFh are acted on and every other command is dropped. FFh ends any busy period on the next clock, clears pending sequences and the fail bit, and returns to data output.
- R10: After 80h, any command other than 10h or FFh abandons the program and takes effect as its own command. A later 10h then starts nothing.
- R11: Status output stays selected until 00h arrives. The 00h returns to page output at the column held before, with no address needed.
- R12: With `wp_ni` low, 10h and D0h start no busy period. If `wp_ni` drops during a program or erase busy period, that period ends at once and status bit 0 reads 1.
- R13: `io_o` is 00h after reset. It changes only on the clock after a read-strobe falling edge seen with `ce_ni` low. `rdy_o` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low |
| cle_i | input | 1 | Command select |
| ale_i | input | 1 | Address select |
| we_ni | input | 1 | Write strobe, active low, byte taken on rising edge |
| re_ni | input | 1 | Read strobe, active low, byte produced on falling edge |
| wp_ni | input | 1 | Write protect, active low |
| io_i | input | 8 | Byte bus into the device |
| io_o | output | 8 | Registered byte returned to the host |
| rdy_o | output | 1 | 1 when ready, 0 while busy |
| page_o | output | 16 | Latched page address |

## Verification
The bench keeps `PAGE_BYTES` at its default of 2112 and shortens the busy periods to `READ_BUSY`=5, `PROG_BUSY`=40 and `ERASE_BUSY`=30. With these values, each busy length can be counted to the exact cycle. The 40-cycle program period is also long enough for a dropped command, a status command and a status read to land inside it. The same window is used to lower the write protect partway through an erase and to issue FFh while busy.

// File: rtl/nand_ctl_pkg.sv
package nand_ctl_pkg;
  localparam int COL_W  = 12;
  localparam int PAGE_W = 16;

  localparam logic [7:0] C_RD       = 8'h00;
  localparam logic [7:0] C_RD_GO    = 8'h30;
  localparam logic [7:0] C_COL      = 8'h05;
  localparam logic [7:0] C_COL_GO   = 8'hE0;
  localparam logic [7:0] C_PGM      = 8'h80;
  localparam logic [7:0] C_PGM_GO   = 8'h10;
  localparam logic [7:0] C_ERS      = 8'h60;
  localparam logic [7:0] C_ERS_GO   = 8'hD0;
  localparam logic [7:0] C_IDENT    = 8'h90;
  localparam logic [7:0] C_STAT     = 8'h70;
  localparam logic [7:0] C_RST      = 8'hFF;

  typedef enum logic [2:0] {P_NONE, P_RD, P_COL, P_PGM, P_ERS, P_IDENT} pend_e;
  typedef enum logic [1:0] {O_DATA, O_STAT, O_IDENT} omode_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h98;
      3'd1:    return 8'hF1;
      3'd2:    return 8'h00;
      3'd3:    return 8'h15;
      default: return 8'h40;
    endcase
  endfunction
endpackage

// File: rtl/nand_edge.sv
module nand_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic en_i,
  output logic pulse_o
);
  logic q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= 1'b1;
    else         q <= sig_i;

  generate
    if (RISING) begin : g_rise
      assign pulse_o = en_i & sig_i & ~q;
    end else begin : g_fall
      assign pulse_o = en_i & ~sig_i & q;
    end
  endgenerate
endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] len_i,
  input  logic         abort_i,
  output logic         busy_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               cnt_q <= '0;
    else if (abort_i)          cnt_q <= '0;
    else if (start_i)          cnt_q <= len_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == W'(1)) & ~abort_i;
endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int DEPTH = 2112,
  parameter int AW    = 12
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i)
    if (we_i && (int'(waddr_i) < DEPTH)) mem[waddr_i] <= wdata_i;

  assign rdata_o = (int'(raddr_i) < DEPTH) ? mem[raddr_i] : 8'hFF;
endmodule

// File: rtl/nand_cmd_decoder.sv
module nand_cmd_decoder
  import nand_ctl_pkg::*;
#(
  parameter int PAGE_BYTES = 2112,
  parameter int READ_BUSY  = 25,
  parameter int PROG_BUSY  = 200,
  parameter int ERASE_BUSY = 400
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ce_ni,
  input  logic        cle_i,
  input  logic        ale_i,
  input  logic        we_ni,
  input  logic        re_ni,
  input  logic        wp_ni,
  input  logic [7:0]  io_i,
  output logic [7:0]  io_o,
  output logic        rdy_o,
  output logic [15:0] page_o
);
  localparam int MAXB = (READ_BUSY > PROG_BUSY)
                        ? ((READ_BUSY > ERASE_BUSY) ? READ_BUSY : ERASE_BUSY)
                        : ((PROG_BUSY > ERASE_BUSY) ? PROG_BUSY : ERASE_BUSY);
  localparam int TW = $clog2(MAXB + 1);

  logic we_rise, re_fall;
  nand_edge #(.RISING(1'b1)) u_we (.clk_i, .rst_ni, .sig_i(we_ni), .en_i(~ce_ni), .pulse_o(we_rise));
  nand_edge #(.RISING(1'b0)) u_re (.clk_i, .rst_ni, .sig_i(re_ni), .en_i(~ce_ni), .pulse_o(re_fall));

  pend_e              pend_q;
  omode_e             omode_q;
  logic [2:0]         acnt_q;
  logic [COL_W-1:0]   col_q;
  logic [PAGE_W-1:0]  page_q;
  logic [2:0]         id_q;
  logic               fail_q, pe_q;
  logic [7:0]         dout_q;

  logic cmd_stb, adr_stb, dat_stb;
  assign cmd_stb = we_rise & cle_i & ~ale_i;
  assign adr_stb = we_rise & ale_i & ~cle_i;
  assign dat_stb = we_rise & ~ale_i & ~cle_i;

  logic busy, done, start, abort;
  logic [TW-1:0] len;

  always_comb begin
    start = 1'b0;
    len   = '0;
    abort = 1'b0;
    if (cmd_stb && !busy) begin
      if (io_i == C_RD_GO && pend_q == P_RD) begin
        start = 1'b1; len = TW'(READ_BUSY);
      end else if (io_i == C_PGM_GO && pend_q == P_PGM && wp_ni) begin
        start = 1'b1; len = TW'(PROG_BUSY);
      end else if (io_i == C_ERS_GO && pend_q == P_ERS && wp_ni) begin
        start = 1'b1; len = TW'(ERASE_BUSY);
      end
    end
    if (cmd_stb && io_i == C_RST) abort = 1'b1;
    if (busy && pe_q && !wp_ni)   abort = 1'b1;
  end

  nand_busy_timer #(.W(TW)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .len_i(len), .abort_i(abort),
    .busy_o(busy), .done_o(done)
  );

  logic       buf_we;
  logic [7:0] buf_rd;
  assign buf_we = dat_stb & ~busy & (pend_q == P_PGM);

  nand_page_buf #(.DEPTH(PAGE_BYTES), .AW(COL_W)) u_buf (
    .clk_i, .we_i(buf_we), .waddr_i(col_q), .wdata_i(io_i),
    .raddr_i(col_q), .rdata_o(buf_rd)
  );

  logic [7:0] stat;
  assign stat = {wp_ni, 1'b0, ~busy, 4'b0000, fail_q};

  logic [7:0] sel;
  always_comb
    case (omode_q)
      O_STAT:  sel = stat;
      O_IDENT: sel = id_byte(id_q);
      default: sel = buf_rd;
    endcase

  logic col_ok;
  assign col_ok = int'(col_q) < PAGE_BYTES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= P_NONE;
      omode_q <= O_DATA;
      acnt_q  <= 3'd4;
      col_q   <= '0;
      page_q  <= '0;
      id_q    <= '0;
      fail_q  <= 1'b0;
      pe_q    <= 1'b0;
      dout_q  <= '0;
    end else begin
      if (start) pe_q <= (io_i != C_RD_GO);
      if (done && pe_q) fail_q <= 1'b0;
      if (busy && pe_q && !wp_ni) fail_q <= 1'b1;

      if (cmd_stb && busy) begin
        if (io_i == C_STAT) omode_q <= O_STAT;
        if (io_i == C_RST) begin
          pend_q <= P_NONE; omode_q <= O_DATA; fail_q <= 1'b0;
        end
      end else if (cmd_stb) begin
        case (io_i)
          C_RD:     begin pend_q <= P_RD;  acnt_q <= 3'd0; omode_q <= O_DATA; end
          C_RD_GO,
          C_PGM_GO,
          C_ERS_GO: pend_q <= P_NONE;
          C_COL:    begin pend_q <= P_COL; acnt_q <= 3'd0; end
          C_COL_GO: begin
            if (pend_q == P_COL) omode_q <= O_DATA;
            pend_q <= P_NONE;
          end
          C_PGM:    begin pend_q <= P_PGM; acnt_q <= 3'd0; end
          C_ERS:    begin pend_q <= P_ERS; acnt_q <= 3'd2; end
          C_IDENT:  begin pend_q <= P_IDENT; acnt_q <= 3'd0; omode_q <= O_IDENT; id_q <= '0; end
          C_STAT:   begin pend_q <= P_NONE; omode_q <= O_STAT; end
          C_RST:    begin pend_q <= P_NONE; omode_q <= O_DATA; fail_q <= 1'b0; end
          default:  ;
        endcase
      end

      if (adr_stb && !busy && acnt_q < 3'd4) begin
        case (acnt_q)
          3'd0:    col_q[7:0]        <= io_i;
          3'd1:    col_q[COL_W-1:8]  <= io_i[COL_W-9:0];
          3'd2:    page_q[7:0]       <= io_i;
          default: page_q[PAGE_W-1:8] <= io_i;
        endcase
        acnt_q <= acnt_q + 3'd1;
        if (pend_q == P_IDENT) id_q <= '0;
      end else if (buf_we && col_ok) begin
        col_q <= col_q + 1'b1;
      end else if (re_fall) begin
        dout_q <= sel;
        if (omode_q == O_DATA && !busy && col_ok) col_q <= col_q + 1'b1;
        if (omode_q == O_IDENT && id_q < 3'd4)    id_q <= id_q + 3'd1;
      end
    end
  end

  assign io_o   = dout_q;
  assign rdy_o  = ~busy;
  assign page_o = page_q;
endmodule

// File: rtl/nand_cmd_checker.sv
module nand_cmd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_ni,
  input logic       cle_i,
  input logic       ale_i,
  input logic       we_ni,
  input logic       re_ni,
  input logic       wp_ni,
  input logic [7:0] io_i,
  input logic [7:0] io_o,
  input logic       rdy_o
);
  // busy only begins right after a start command (R3, R5, R6)
  assert_busy_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> ($past(we_ni) && !$past(we_ni, 2) && $past(cle_i) && !$past(ce_ni) &&
                      ($past(io_i) == 8'h30 || $past(io_i) == 8'h10 || $past(io_i) == 8'hD0)));

  // protect low: only a read may start a busy period
  assert_wp_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rdy_o) && !$past(wp_ni)) |-> ($past(io_i) == 8'h30));

  // reset command ends busy on the next clock
  assert_reset_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we_ni) && we_ni && !ce_ni && cle_i && !ale_i && io_i == 8'hFF) |=> rdy_o);

  // output byte moves only after a read-strobe falling edge
  assert_out_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(io_o) |-> (!$past(re_ni) && $past(re_ni, 2) && !$past(ce_ni)));
endmodule

bind nand_cmd_decoder nand_cmd_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_ni(ce_ni), .cle_i(cle_i), .ale_i(ale_i),
  .we_ni(we_ni), .re_ni(re_ni), .wp_ni(wp_ni), .io_i(io_i), .io_o(io_o), .rdy_o(rdy_o)
);

// File: tb/tb_nand_cmd_decoder.sv
module tb_nand_cmd_decoder;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic ce_ni = 1'b1, cle_i = 1'b0, ale_i = 1'b0, we_ni = 1'b1, re_ni = 1'b1, wp_ni = 1'b1;
  logic [7:0] io_i = '0, io_o;
  logic rdy_o;
  logic [15:0] page_o;
  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  nand_cmd_decoder #(.PAGE_BYTES(2112), .READ_BUSY(5), .PROG_BUSY(40), .ERASE_BUSY(30)) dut (
    .clk_i(clk), .rst_ni, .ce_ni, .cle_i, .ale_i, .we_ni, .re_ni, .wp_ni,
    .io_i, .io_o, .rdy_o, .page_o
  );

  typedef enum logic [2:0] {K_C, K_A, K_D, K_R, K_W} kind_e;
  typedef struct packed { kind_e k; logic [7:0] v; logic [3:0] r; } vec_t;
  localparam int NV = 54;
  localparam vec_t VEC [NV] = '{
    '{K_C,8'h80,4'd5}, '{K_A,8'h10,4'd5}, '{K_A,8'h00,4'd5}, '{K_A,8'h41,4'd5}, '{K_A,8'h00,4'd5}, // R5
    '{K_D,8'hA5,4'd5}, '{K_D,8'h5A,4'd5}, '{K_D,8'h3C,4'd5}, '{K_C,8'h10,4'd5}, '{K_W,8'd40,4'd5},
    '{K_C,8'h70,4'd7}, '{K_R,8'hA0,4'd7},                                                       // R7
    '{K_C,8'h00,4'd3}, '{K_A,8'h10,4'd3}, '{K_A,8'h00,4'd3}, '{K_A,8'h41,4'd3}, '{K_A,8'h00,4'd3}, // R3
    '{K_C,8'h30,4'd3}, '{K_W,8'd5,4'd3},  '{K_R,8'hA5,4'd3}, '{K_R,8'h5A,4'd3},
    '{K_C,8'h70,4'd11}, '{K_R,8'hA0,4'd11}, '{K_C,8'h00,4'd11}, '{K_R,8'h3C,4'd11},             // R11
    '{K_C,8'h05,4'd4}, '{K_A,8'h11,4'd4}, '{K_A,8'h00,4'd4}, '{K_C,8'hE0,4'd4},                 // R4
    '{K_R,8'h5A,4'd4}, '{K_R,8'h3C,4'd4},
    '{K_C,8'h90,4'd8}, '{K_A,8'h00,4'd8}, '{K_R,8'h98,4'd8}, '{K_R,8'hF1,4'd8},                 // R8
    '{K_R,8'h00,4'd8}, '{K_R,8'h15,4'd8}, '{K_R,8'h40,4'd8},
    '{K_C,8'h60,4'd6}, '{K_A,8'h41,4'd6}, '{K_A,8'h00,4'd6}, '{K_C,8'hD0,4'd6},                 // R6
    '{K_W,8'd30,4'd6}, '{K_C,8'h70,4'd6}, '{K_R,8'hA0,4'd6},
    '{K_C,8'h00,4'd2}, '{K_A,8'h10,4'd2}, '{K_A,8'h00,4'd2}, '{K_A,8'h41,4'd2}, '{K_A,8'h00,4'd2}, // R2
    '{K_A,8'h07,4'd2}, '{K_C,8'h30,4'd2}, '{K_W,8'd5,4'd2},  '{K_R,8'hA5,4'd2}
  };

  task automatic chk(input int rq, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] v, input logic ce = 1'b0);
    @(negedge clk); ce_ni = ce; cle_i = c; ale_i = a; io_i = v; we_ni = 1'b0;
    @(negedge clk); we_ni = 1'b1;
    @(negedge clk); cle_i = 1'b0; ale_i = 1'b0; ce_ni = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); ce_ni = 1'b0; re_ni = 1'b0;
    @(negedge clk); re_ni = 1'b1;
    @(negedge clk); v = io_o;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!rdy_o && n < 1000) begin n++; @(negedge clk); end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int n;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(13, {15'd0, rdy_o}, 16'd1);    // R13 reset state
    chk(13, {8'd0, io_o}, 16'h0000);   // R13
    chk(2, page_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].k)
        K_C: wr(1'b1, 1'b0, VEC[i].v);
        K_A: wr(1'b0, 1'b1, VEC[i].v);
        K_D: wr(1'b0, 1'b0, VEC[i].v);
        K_R: begin rd(b); chk(int'(VEC[i].r), {8'd0, b}, {8'd0, VEC[i].v}); end
        default: begin wait_rdy(n); chk(int'(VEC[i].r), 16'(n), {8'd0, VEC[i].v}); end
      endcase
    end
    chk(2, page_o, 16'h0041);          // R2 fifth byte ignored

    // R1: strobes with chip select high change nothing
    wr(1'b1, 1'b0, 8'h70, 1'b1);
    rd(b); chk(1, {8'd0, b}, 16'h005A);

    // R13: command write leaves io_o alone
    wr(1'b1, 1'b0, 8'hF0);
    chk(13, {8'd0, io_o}, 16'h005A);

    // R9: busy drops ID command, accepts status
    wr(1'b1,1'b0,8'h80); wr(1'b0,1'b1,8'h20); wr(1'b0,1'b1,8'h00);
    wr(1'b0,1'b1,8'h41); wr(1'b0,1'b1,8'h00); wr(1'b0,1'b0,8'h11);
    wr(1'b1,1'b0,8'h10);
    chk(9, {15'd0, rdy_o}, 16'd0);
    wr(1'b1,1'b0,8'h90);
    wr(1'b1,1'b0,8'h70);
    rd(b); chk(9, {8'd0, b}, 16'h0080);
    wait_rdy(n);
    rd(b); chk(9, {8'd0, b}, 16'h00A0);

    // R9: reset command ends erase busy
    wr(1'b1,1'b0,8'h60); wr(1'b0,1'b1,8'h41); wr(1'b0,1'b1,8'h00); wr(1'b1,1'b0,8'hD0);
    chk(9, {15'd0, rdy_o}, 16'd0);
    wr(1'b1,1'b0,8'hFF);
    chk(9, {15'd0, rdy_o}, 16'd1);

    // R10: ID command abandons program, later 10h does nothing
    wr(1'b1,1'b0,8'h80); wr(1'b0,1'b1,8'h30); wr(1'b0,1'b1,8'h00);
    wr(1'b0,1'b1,8'h41); wr(1'b0,1'b1,8'h00); wr(1'b0,1'b0,8'h77);
    wr(1'b1,1'b0,8'h90); wr(1'b1,1'b0,8'h10);
    chk(10, {15'd0, rdy_o}, 16'd1);
    rd(b); chk(10, {8'd0, b}, 16'h0098);

    // R12: protect inhibits program
    wp_ni = 1'b0;
    wr(1'b1,1'b0,8'h80); wr(1'b0,1'b1,8'h40); wr(1'b0,1'b1,8'h00);
    wr(1'b0,1'b1,8'h41); wr(1'b0,1'b1,8'h00); wr(1'b0,1'b0,8'h01);
    wr(1'b1,1'b0,8'h10);
    chk(12, {15'd0, rdy_o}, 16'd1);
    wr(1'b1,1'b0,8'h70);
    rd(b); chk(12, {8'd0, b}, 16'h0020);

    // R12: protect dropped mid-erase aborts and flags failure
    wp_ni = 1'b1;
    wr(1'b1,1'b0,8'h60); wr(1'b0,1'b1,8'h41); wr(1'b0,1'b1,8'h00); wr(1'b1,1'b0,8'hD0);
    chk(12, {15'd0, rdy_o}, 16'd0);
    wp_ni = 1'b0;
    @(negedge clk);
    chk(12, {15'd0, rdy_o}, 16'd1);
    rd(b); chk(12, {8'd0, b}, 16'h0021);
    wp_ni = 1'b1;
    rd(b); chk(7, {8'd0, b}, 16'h00A1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule